// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models the device side of a three-wire serial EEPROM holding 1024 bits in flip-flops. A host drives chip select, a shift clock and a serial data line. The block answers on a serial data output with an explicit output enable, which is low whenever the output would float. A static organization input chooses the view of the same storage: either 64 words of 16 bits or 128 bytes. All three host inputs are brought into the system clock domain, and each rising edge of the shift clock is handled as a single-cycle event.

Each frame begins with a start bit, followed by a 2-bit opcode and an address. A write or erase frame arms the block. The self-timed operation then starts when chip select falls, and the new contents are committed only when a programmable cycle count has elapsed. A write-enable latch gates every modifying command. If chip select is raised again while the operation is still running, the output shows busy and then ready.

The controller has nine states: `S_IDLE`, `S_OPC`, `S_ADDR`, `S_DATA`, `S_READ`, `S_ARMED`, `S_BUSY`, `S_READY` and `S_SKIP`. Its transitions are as follows:

- IDLE→OPC on a 1 sampled at a shift-clock rise.
- OPC→ADDR after two opcode bits.
- ADDR→READ for a read.
- ADDR→DATA for a write or write-all while enabled.
- ADDR→ARMED for an erase or erase-all while enabled.
- ADDR→SKIP for the latch commands, and for any modifying command while disabled.
- DATA→ARMED after the last data bit.
- ARMED→BUSY when chip select falls.
- BUSY→READY when the timer ends with chip select high, or BUSY→IDLE when it ends with chip select low.
- READY→IDLE when chip select falls.
- OPC, ADDR, DATA, READ and SKIP each return to IDLE when chip select falls.

Top module: `tw_eeprom`

## Requirements
- R1: After reset the output enable is low, the write-enable latch is clear, and every storage bit reads as 1.
- R2: While chip select is low, `so_oe` is 0, and a frame in progress is dropped. The exception is a write that has already started, which completes.
- R3: Zeros before the start bit are ignored. A frame is: a start bit of 1, then opcode bits (read 10, write 01, erase 11, extended 00), then the address MSB first. All bits are sampled on rising shift-clock edges.
- R4: With `org_wide`=1 the address is 6 bits and selects a 16-bit word. With `org_wide`=0 it is 7 bits and selects a byte: address bit 0 = 1 selects bits 15:8 of word addr[6:1], and 0 selects bits 7:0.
- R5: After the last address bit of a read, the output is driven with a 0. Each following shift-clock rise then presents the next data bit, MSB first.
- R6: If shift clocks continue after the last bit of a read, the data of the next address follows with no extra 0. The address wraps from the highest location to 0.
- R7: A write carries 16 (word) or 8 (byte) data bits, MSB first, and replaces the old contents without a prior erase.
- R8: An extended frame with the top two address bits 11 sets the write-enable latch, and one with 00 clears it. While the latch is clear, write, erase, write-all and erase-all change nothing and start no busy period.
- R9: Erase sets every bit of the addressed word or byte to 1.
- R10: An extended frame with top address bits 10 sets the whole array to 1. One with 01 takes a data field and writes it to every word (in byte mode, to every byte).
- R11: A modifying operation starts when chip select falls after a complete frame. It lasts `WR_CYCLES` clock cycles, and the storage changes only at its end.
- R12: While the operation runs and chip select is high, the output is enabled and low. After it ends with chip select still high, the output is enabled and high until chip select falls.
- R13: If chip select falls before the last data bit of a write, no operation starts and the storage keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| org_wide | input | 1 | Organization select: 1 = 16-bit words, 0 = bytes |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial shift clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |

## Verification
Reads are run on the blank array, on word data with mixed bit values, and on byte lanes in both halves of one word. Continued clocking is checked both after a fresh address and across the wrap from the last word to word 0, which separates a correct sequential read from one that repeats, re-inserts the dummy 0, or fails to wrap. Modifying frames are sent in three conditions: with the latch set, with the latch clear (before and after the disable command), and cut short by chip select. The busy/ready level then separates an armed operation from an ignored one. Erase, erase-all and write-all each leave distinct patterns that a read back tells apart from a plain write.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_OPC,
        S_ADDR,
        S_DATA,
        S_READ,
        S_ARMED,
        S_BUSY,
        S_READY,
        S_SKIP
    } eep_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WRITE,
        OP_ERASE,
        OP_WRALL,
        OP_ERALL
    } eep_wop_e;

    // opcode field
    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    // extended sub-codes in the top two address bits
    localparam logic [1:0] EXT_LOCK  = 2'b00;
    localparam logic [1:0] EXT_FILL  = 2'b01;
    localparam logic [1:0] EXT_BLANK = 2'b10;
    localparam logic [1:0] EXT_OPEN  = 2'b11;

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/eep_wtimer.sv
module eep_wtimer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                cnt_q <= CW'(CYCLES - 1);
            end else if (busy) begin
                if (cnt_q == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/eep_array.sv
module eep_array
    import eep_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  eep_wop_e          op,
    input  logic              wide,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int IDX_W = ADDR_W - 1;
    localparam int WORDS = 1 << IDX_W;
    localparam int HALF  = WORD_W / 2;

    logic [WORDS-1:0][WORD_W-1:0] words;
    logic [IDX_W-1:0]             widx;
    logic [IDX_W-1:0]             ridx;
    logic                         whi;

    assign widx  = wide ? waddr[IDX_W-1:0] : waddr[ADDR_W-1:1];
    assign ridx  = wide ? raddr[IDX_W-1:0] : raddr[ADDR_W-1:1];
    assign whi   = waddr[0];
    assign rdata = words[ridx];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [WORD_W-1:0] word_q;
        logic [WORD_W-1:0] word_d;
        logic              hit;

        assign hit = (widx == IDX_W'(g));

        always_comb begin
            word_d = word_q;
            unique case (op)
                OP_WRITE: begin
                    if (hit) begin
                        if (wide)     word_d = wdata;
                        else if (whi) word_d = {wdata[HALF-1:0], word_q[HALF-1:0]};
                        else          word_d = {word_q[WORD_W-1:HALF], wdata[HALF-1:0]};
                    end
                end
                OP_ERASE: begin
                    if (hit) begin
                        if (wide)     word_d = '1;
                        else if (whi) word_d = {{HALF{1'b1}}, word_q[HALF-1:0]};
                        else          word_d = {word_q[WORD_W-1:HALF], {HALF{1'b1}}};
                    end
                end
                OP_WRALL: word_d = wide ? wdata : {2{wdata[HALF-1:0]}};
                OP_ERALL: word_d = '1;
                default:  word_d = word_q;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  word_q <= '1;
            else if (we) word_q <= word_d;
        end

        assign words[g] = word_q;
    end
endmodule

// File: rtl/tw_eeprom.sv
module tw_eeprom
    import eep_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int WORD_W    = 16,
    parameter int WR_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic org_wide,
    input  logic cs,
    input  logic sk,
    input  logic si,
    output logic so,
    output logic so_oe
);
    localparam int HALF  = WORD_W / 2;
    localparam int CNT_W = $clog2(WORD_W + 1);

    eep_state_e        state_q, state_d;
    logic              cs_s, sk_s, si_s, sk_d;
    logic              sk_rise;
    logic [CNT_W-1:0]  cnt_q, rcnt_q;
    logic [CNT_W-1:0]  aw_last, dw_last;
    logic [1:0]        opc_q;
    logic [ADDR_W-1:0] addr_q, addr_sh, addr_nx, raddr;
    logic [WORD_W-1:0] wdat_q, rsh_q, rdata, rload;
    logic              rbit_q, ewen_q;
    eep_wop_e          pend_q;
    logic              last_addr, last_data;
    logic [1:0]        ext_code;
    logic              tmr_start, tmr_busy, tmr_done, arr_we;

    eep_sync #(.W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs, sk, si}),
        .q     ({cs_s, sk_s, si_s})
    );

    // field lengths by organization
    assign aw_last  = org_wide ? CNT_W'(ADDR_W - 2) : CNT_W'(ADDR_W - 1);
    assign dw_last  = org_wide ? CNT_W'(WORD_W - 1) : CNT_W'(HALF - 1);
    assign sk_rise  = sk_s & ~sk_d & cs_s;
    assign addr_sh  = {addr_q[ADDR_W-2:0], si_s};
    assign addr_nx  = org_wide ? {1'b0, addr_q[ADDR_W-2:0] + 1'b1} : addr_q + 1'b1;
    assign ext_code = org_wide ? addr_sh[ADDR_W-2:ADDR_W-3] : addr_sh[ADDR_W-1:ADDR_W-2];
    assign last_addr = (state_q == S_ADDR) && sk_rise && (cnt_q == aw_last);
    assign last_data = (state_q == S_DATA) && sk_rise && (cnt_q == dw_last);

    // read port: next address during a read, incoming address while decoding
    assign raddr = (state_q == S_READ) ? addr_nx : addr_sh;
    assign rload = org_wide ? rdata :
                   (raddr[0] ? {rdata[WORD_W-1:HALF], {HALF{1'b0}}}
                             : {rdata[HALF-1:0], {HALF{1'b0}}});

    assign tmr_start = (state_q == S_ARMED) && !cs_s;
    assign arr_we    = (state_q == S_BUSY) && tmr_done;

    eep_wtimer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    eep_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .op    (pend_q),
        .wide  (org_wide),
        .waddr (addr_q),
        .wdata (wdat_q),
        .raddr (raddr),
        .rdata (rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (sk_rise && si_s) state_d = S_OPC;
            S_OPC: begin
                if (!cs_s)                             state_d = S_IDLE;
                else if (sk_rise && cnt_q == CNT_W'(1)) state_d = S_ADDR;
            end
            S_ADDR: begin
                if (!cs_s) state_d = S_IDLE;
                else if (last_addr) begin
                    unique case (opc_q)
                        OPC_READ:  state_d = S_READ;
                        OPC_WRITE: state_d = ewen_q ? S_DATA : S_SKIP;
                        OPC_ERASE: state_d = ewen_q ? S_ARMED : S_SKIP;
                        default: begin
                            if (ext_code == EXT_FILL)       state_d = ewen_q ? S_DATA : S_SKIP;
                            else if (ext_code == EXT_BLANK) state_d = ewen_q ? S_ARMED : S_SKIP;
                            else                            state_d = S_SKIP;
                        end
                    endcase
                end
            end
            S_DATA: begin
                if (!cs_s)          state_d = S_IDLE;
                else if (last_data) state_d = S_ARMED;
            end
            S_READ:  if (!cs_s) state_d = S_IDLE;
            S_ARMED: if (!cs_s) state_d = S_BUSY;
            S_BUSY:  if (tmr_done) state_d = cs_s ? S_READY : S_IDLE;
            S_READY: if (!cs_s) state_d = S_IDLE;
            S_SKIP:  if (!cs_s) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_d   <= 1'b0;
            cnt_q  <= '0;
            rcnt_q <= '0;
            opc_q  <= '0;
            addr_q <= '0;
            wdat_q <= '0;
            rsh_q  <= '0;
            rbit_q <= 1'b0;
            ewen_q <= 1'b0;
            pend_q <= OP_NONE;
        end else begin
            sk_d <= sk_s;
            if (state_q != state_d) cnt_q <= '0;
            else if (sk_rise)       cnt_q <= cnt_q + 1'b1;

            unique case (state_q)
                S_OPC: if (sk_rise) opc_q <= {opc_q[0], si_s};
                S_ADDR: begin
                    if (sk_rise) addr_q <= addr_sh;
                    if (last_addr) begin
                        rsh_q  <= rload;
                        rbit_q <= 1'b0;
                        rcnt_q <= '0;
                        pend_q <= OP_NONE;
                        unique case (opc_q)
                            OPC_WRITE: pend_q <= OP_WRITE;
                            OPC_ERASE: pend_q <= OP_ERASE;
                            OPC_EXT: begin
                                unique case (ext_code)
                                    EXT_OPEN:  ewen_q <= 1'b1;
                                    EXT_LOCK:  ewen_q <= 1'b0;
                                    EXT_FILL:  pend_q <= OP_WRALL;
                                    EXT_BLANK: pend_q <= OP_ERALL;
                                    default:   pend_q <= OP_NONE;
                                endcase
                            end
                            default: pend_q <= OP_NONE;
                        endcase
                    end
                end
                S_DATA: if (sk_rise) wdat_q <= {wdat_q[WORD_W-2:0], si_s};
                S_READ: begin
                    if (sk_rise) begin
                        rbit_q <= rsh_q[WORD_W-1];
                        if (rcnt_q == dw_last) begin
                            rcnt_q <= '0;
                            addr_q <= addr_nx;
                            rsh_q  <= rload;
                        end else begin
                            rcnt_q <= rcnt_q + 1'b1;
                            rsh_q  <= {rsh_q[WORD_W-2:0], 1'b0};
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        so    = 1'b0;
        so_oe = 1'b0;
        unique case (state_q)
            S_READ: begin
                so    = rbit_q;
                so_oe = cs_s;
            end
            S_BUSY: begin
                so    = 1'b0;
                so_oe = cs_s;
            end
            S_READY: begin
                so    = 1'b1;
                so_oe = cs_s;
            end
            default: begin
                so    = 1'b0;
                so_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/eep_chk.sv
module eep_chk #(
    parameter int WR_CYCLES = 500000
) (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic so,
    input logic so_oe,
    input logic tmr_busy,
    input logic arr_we,
    input logic ewen_q
);
    int busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        busy_run <= 0;
        else if (tmr_busy) busy_run <= busy_run + 1;
        else               busy_run <= 0;
    end

    // R2
    hiz_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |-> !so_oe);

    // R12
    busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_busy && cs_s) |-> (so_oe && !so));

    // R8
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> ewen_q);

    // R11
    start_on_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_busy) |-> $past(!cs_s));

    // R11
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= WR_CYCLES);

    // R11
    commit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> !arr_we);
endmodule

bind tw_eeprom eep_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .so       (so),
    .so_oe    (so_oe),
    .tmr_busy (tmr_busy),
    .arr_we   (arr_we),
    .ewen_q   (ewen_q)
);

// File: tb/test_tw_eeprom.sv
module test_tw_eeprom;
    localparam int WRC = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic org_wide = 1'b1;
    logic cs = 1'b0;
    logic sk = 1'b0;
    logic si = 1'b0;
    logic so, so_oe;
    int   checks = 0;
    int   fails = 0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    tw_eeprom #(.ADDR_W(7), .WORD_W(16), .WR_CYCLES(WRC)) i_tw_eeprom (
        .clk(clk), .rst_n(rst_n), .org_wide(org_wide),
        .cs(cs), .sk(sk), .si(si), .so(so), .so_oe(so_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(input logic b);
        si = b; wclk(4); sk = 1'b1; wclk(8); sk = 1'b0; wclk(4);
    endtask

    task automatic shift(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(v[i]);
    endtask

    task automatic cmd(input logic [1:0] op, input logic [6:0] a, input int aw, input int lz);
        cs = 1'b1; wclk(4);
        for (int i = 0; i < lz; i++) pulse(1'b0);
        pulse(1'b1);
        shift({14'b0, op}, 2);
        shift({9'b0, a}, aw);
    endtask

    task automatic fin();
        cs = 1'b0; si = 1'b0; wclk(8);
    endtask

    // raise chip select after a frame and look at status
    task automatic status_check(input string req, input bit armed);
        fin();
        cs = 1'b1; wclk(8);
        if (armed) chk(so_oe === 1'b1 && so === 1'b0, {req, " busy"}, {so_oe, so}, 2'b10);
        else       chk(so_oe === 1'b0, {req, " no busy"}, so_oe, 0);
        wclk(WRC + 10);
        if (armed) chk(so_oe === 1'b1 && so === 1'b1, {req, " ready"}, {so_oe, so}, 2'b11);
        fin();
        chk(so_oe === 1'b0, "R2 released", so_oe, 0);
    endtask

    task automatic read_chk(input logic [6:0] a, input int aw, input int dw,
                            input logic [15:0] e0, input logic [15:0] e1,
                            input int lz, input string req);
        logic [15:0] v0, v1;
        v0 = '0; v1 = '0;
        cmd(2'b10, a, aw, lz);
        chk(so_oe === 1'b1 && so === 1'b0, "R5 dummy zero", {so_oe, so}, 2'b10);
        for (int i = 0; i < dw; i++) begin pulse(1'b0); v0 = {v0[14:0], so}; end
        for (int i = 0; i < dw; i++) begin pulse(1'b0); v1 = {v1[14:0], so}; end
        chk(v0 === e0, {req, " first"}, v0, e0);
        chk(v1 === e1, "R6 next location", v1, e1);
        fin();
        chk(so_oe === 1'b0, "R2 hi-z after read", so_oe, 0);
    endtask

    task automatic t_reset();
        chk(so_oe === 1'b0, "R1 oe at reset", so_oe, 0);
        read_chk(7'd0, 6, 16, 16'hFFFF, 16'hFFFF, 2, "R1 R3 blank");
    endtask

    task automatic t_locked_write();
        cmd(2'b01, 7'd3, 6, 0); shift(16'h1234, 16);
        status_check("R8 locked", 1'b0);
        read_chk(7'd3, 6, 16, 16'hFFFF, 16'hFFFF, 0, "R8 unchanged");
    endtask

    task automatic t_word_write();
        cmd(2'b00, 7'b0110000, 6, 0); fin();
        cmd(2'b01, 7'd5, 6, 0); shift(16'hA5C3, 16);
        status_check("R12 R11", 1'b1);
        read_chk(7'd5, 6, 16, 16'hA5C3, 16'hFFFF, 0, "R7 word");
    endtask

    task automatic t_byte();
        org_wide = 1'b0; wclk(4);
        cmd(2'b01, 7'h0B, 7, 0); shift(16'h003C, 8);
        status_check("R4 byte", 1'b1);
        read_chk(7'h0A, 7, 8, 16'h00C3, 16'h003C, 0, "R4 byte lanes");
        org_wide = 1'b1; wclk(4);
        read_chk(7'd5, 6, 16, 16'h3CC3, 16'hFFFF, 0, "R4 word view");
    endtask

    task automatic t_erase();
        cmd(2'b11, 7'd5, 6, 0);
        status_check("R9 erase", 1'b1);
        read_chk(7'd5, 6, 16, 16'hFFFF, 16'hFFFF, 0, "R9 erased");
    endtask

    task automatic t_wrap();
        cmd(2'b01, 7'd63, 6, 0); shift(16'h1234, 16);
        status_check("R7 last word", 1'b1);
        read_chk(7'd63, 6, 16, 16'h1234, 16'hFFFF, 0, "R6 wrap");
    endtask

    task automatic t_abort();
        cmd(2'b01, 7'd7, 6, 0); shift(16'h00AB, 8);
        status_check("R13 abort", 1'b0);
        read_chk(7'd7, 6, 16, 16'hFFFF, 16'hFFFF, 0, "R13 kept");
    endtask

    task automatic t_bulk();
        cmd(2'b00, 7'b0010000, 6, 0); shift(16'h5A5A, 16);
        status_check("R10 fill", 1'b1);
        read_chk(7'd40, 6, 16, 16'h5A5A, 16'h5A5A, 0, "R10 fill");
        cmd(2'b00, 7'b0100000, 6, 0);
        status_check("R10 blank", 1'b1);
        read_chk(7'd3, 6, 16, 16'hFFFF, 16'hFFFF, 0, "R10 blank");
    endtask

    task automatic t_lock_again();
        cmd(2'b00, 7'b0000000, 6, 0); fin();
        cmd(2'b01, 7'd9, 6, 0); shift(16'h0000, 16);
        status_check("R8 relocked", 1'b0);
        read_chk(7'd9, 6, 16, 16'hFFFF, 16'hFFFF, 0, "R8 relocked");
    endtask

    initial begin
        wclk(5); rst_n = 1'b1; wclk(5);
        t_reset();
        t_locked_write();
        t_word_write();
        t_byte();
        t_erase();
        t_wrap();
        t_abort();
        t_bulk();
        t_lock_again();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule